// File: doc/BRIEF.md
# Configurable pin register cell

This block holds the per-pin storage of a programmable IO cell. It carries three independent paths: data arriving from the pad towards the core, data leaving the core towards the pad, and the output-enable that drives the pad's tri-state control. Each path has its own storage element and its own 7-bit configuration word. That word decides whether the element samples on a clock edge or acts as a transparent latch, and which level of clock, enable and set/reset counts as active. It also decides whether set/reset is synchronous or asynchronous, which value (0 or 1) it loads, and whether the path skips the storage element altogether.

The paths share one clock and one set/reset pin. The pad-to-core path has its own enable, and the two pad-facing paths share a second enable. A chip-level asynchronous active-low reset is synchronised on release and loads every storage element with its configured initial value. Configuration words are expected to change only while reset is held.

Top module: `pin_regcell`

## Requirements
- R1: With configuration bit 0 clear (edge mode), a path's stored value takes its data input on the active clock edge when the effective enable is active. Bit 1 clear selects the rising edge of `clk` and bit 1 set selects the falling edge. With enable inactive the stored value holds.
- R2: With bit 0 set (latch mode), the stored value follows its data input while the gate is open and the effective enable is active, and holds otherwise. The gate is open while `clk` is high if bit 1 is clear, and while `clk` is low if bit 1 is set.
- R3: Bit 2 clear makes the enable active high, and bit 2 set makes it active low.
- R4: With bit 4 clear (synchronous set/reset), an active `sr` loads the initial value whenever the element samples, i.e. on the active edge or while the gate is open. It wins over data and does not need the enable. Bit 3 clear makes `sr` active high, and bit 3 set makes it active low.
- R5: With bit 4 set (asynchronous set/reset), an active `sr` forces the stored value to the initial value at once, whatever the clock, enable and data. The value stays until the next capture after `sr` goes inactive.
- R6: Bit 5 gives the initial value: 0 gives a clear and 1 gives a set. Both `sr` and the chip reset load it.
- R7: `rst_n` low forces every stored value to its initial value at once. After `rst_n` rises, the elements stay forced through the next two rising edges of `clk`, so the first rising-edge capture happens on the third rising edge.
- R8: With bit 6 set, the path output equals the path's data input combinationally, and its storage element has no effect on the output.
- R9: The three paths work independently, each under its own configuration word: `pad_in` to `core_din` with `cfg_in` and `ce_in`, `core_dout` to `pad_dout` with `cfg_out` and `ce_out`, and `core_oe` to `pad_oe` with `cfg_oe` and `ce_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pin clock, also used as latch gate |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| cfg_in | input | 7 | Configuration word of the pad-to-core path |
| cfg_out | input | 7 | Configuration word of the core-to-pad data path |
| cfg_oe | input | 7 | Configuration word of the output-enable path |
| ce_in | input | 1 | Enable for the pad-to-core path |
| ce_out | input | 1 | Enable shared by data-out and output-enable paths |
| sr | input | 1 | Shared set/reset request |
| pad_in | input | 1 | Data arriving from the pad |
| core_dout | input | 1 | Data from the core towards the pad |
| core_oe | input | 1 | Output enable from the core |
| core_din | output | 1 | Pad data delivered to the core |
| pad_dout | output | 1 | Data driven to the pad |
| pad_oe | output | 1 | Tri-state control driven to the pad |

## Verification
Every one of the 64 mode, polarity, timing and init-value combinations is run on each path, with random data, enable and set/reset streams applied a quarter period after the rising edge. That placement separates rising-edge capture (previous cycle's inputs), falling-edge capture and latch transparency (current inputs). The set/reset stream tells synchronous from asynchronous action, because an asynchronous request shows before the next active edge. A held-enable sequence across reset release pins the capture to the third rising edge. A data change in the middle of an open low-level gate, followed by one after the gate closes, separates a latch from a falling-edge register.

// File: rtl/pin_regcell_pkg.sv
package pin_regcell_pkg;

  localparam int NPATH = 3;

  // LSB first: latch, clk_fall, ce_low, sr_low, sr_async, init_val, bypass
  typedef struct packed {
    logic bypass;
    logic init_val;
    logic sr_async;
    logic sr_low;
    logic ce_low;
    logic clk_fall;
    logic latch;
  } store_cfg_t;

  localparam int CFG_W = $bits(store_cfg_t);

endpackage

// File: rtl/pin_rst_sync.sv
module pin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pin_store.sv
module pin_store
  import pin_regcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  store_cfg_t cfg,
  input  logic       d,
  input  logic       ce,
  input  logic       sr,
  output logic       y
);

  logic gate, en, sr_act, sync_hit, arst;
  logic flop_q, flop_nxt;
  logic lat_q, lat_nxt, lat_open;
  logic st_q;

  // polarity-corrected controls
  always_comb begin
    gate     = clk ^ cfg.clk_fall;
    en       = ce ^ cfg.ce_low;
    sr_act   = sr ^ cfg.sr_low;
    sync_hit = sr_act & ~cfg.sr_async;
    arst     = ~rst_sync_n | (sr_act & cfg.sr_async);
  end

  // edge-triggered element
  always_comb begin
    if (sync_hit)  flop_nxt = cfg.init_val;
    else if (en)   flop_nxt = d;
    else           flop_nxt = flop_q;
  end

  always_ff @(posedge gate or posedge arst) begin
    if (arst) flop_q <= cfg.init_val;
    else      flop_q <= flop_nxt;
  end

  // level-sensitive element
  always_comb begin
    lat_open = gate & (en | sync_hit);
    lat_nxt  = sync_hit ? cfg.init_val : d;
  end

  always_latch begin
    if (arst)          lat_q <= cfg.init_val;
    else if (lat_open) lat_q <= lat_nxt;
  end

  always_comb begin
    st_q = cfg.latch ? lat_q : flop_q;
    y    = cfg.bypass ? d : st_q;
  end

  // R5: asynchronous request holds the stored value at the init value
  p_async_force_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg.sr_async && sr_act) |-> (st_q == cfg.init_val));

  // R1: rising-edge capture with enable active
  p_edge_capture_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !cfg.latch && !cfg.clk_fall && !cfg.sr_async && !sr_act && en)
    |=> (st_q == $past(d)));

  // R1: falling-edge capture with enable active
  p_fall_capture_r1: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !cfg.latch && cfg.clk_fall && !cfg.sr_async && !sr_act && en)
    |=> (st_q == $past(d)));

  // R3: inactive enable keeps the edge element unchanged
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !cfg.latch && !cfg.clk_fall && !cfg.sr_async && !sr_act && !en)
    |=> $stable(st_q));

  // R4: synchronous request loads the init value on the edge
  p_sync_load_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !cfg.latch && !cfg.clk_fall && !cfg.sr_async && sr_act)
    |=> (st_q == cfg.init_val));

endmodule

// File: rtl/pin_regcell.sv
module pin_regcell
  import pin_regcell_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic [CFG_W-1:0] cfg_out,
  input  logic [CFG_W-1:0] cfg_oe,
  input  logic             ce_in,
  input  logic             ce_out,
  input  logic             sr,
  input  logic             pad_in,
  input  logic             core_dout,
  input  logic             core_oe,
  output logic             core_din,
  output logic             pad_dout,
  output logic             pad_oe
);

  logic             rst_sync_n;
  store_cfg_t       cfg_a [NPATH];
  logic [NPATH-1:0] d_v;
  logic [NPATH-1:0] ce_v;
  logic [NPATH-1:0] y_v;

  pin_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // path 0: pad->core, path 1: core->pad data, path 2: output enable
  always_comb begin
    cfg_a[0] = store_cfg_t'(cfg_in);
    cfg_a[1] = store_cfg_t'(cfg_out);
    cfg_a[2] = store_cfg_t'(cfg_oe);
    d_v      = {core_oe, core_dout, pad_in};
    ce_v     = {ce_out, ce_out, ce_in};
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    pin_store i_store (
      .clk        (clk),
      .rst_sync_n (rst_sync_n),
      .cfg        (cfg_a[p]),
      .d          (d_v[p]),
      .ce         (ce_v[p]),
      .sr         (sr),
      .y          (y_v[p])
    );
  end

  assign core_din = y_v[0];
  assign pad_dout = y_v[1];
  assign pad_oe   = y_v[2];

endmodule

// File: tb/test_pin_regcell.sv
module test_pin_regcell;
  import pin_regcell_pkg::*;

  logic       clk, rst_n;
  logic [6:0] cfg_in, cfg_out, cfg_oe;
  logic       ce_in, ce_out, sr, pad_in, core_dout, core_oe;
  logic       core_din, pad_dout, pad_oe;

  int         total, bad, rst_cnt;
  logic [2:0] mq;

  typedef struct {
    int    path;
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  pin_regcell i_pin_regcell (
    .clk(clk), .rst_n(rst_n),
    .cfg_in(cfg_in), .cfg_out(cfg_out), .cfg_oe(cfg_oe),
    .ce_in(ce_in), .ce_out(ce_out), .sr(sr),
    .pad_in(pad_in), .core_dout(core_dout), .core_oe(core_oe),
    .core_din(core_din), .pad_dout(pad_dout), .pad_oe(pad_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [6:0] pcfg(int p);
    return (p == 0) ? cfg_in : (p == 1) ? cfg_out : cfg_oe;
  endfunction
  function automatic logic pd(int p);
    return (p == 0) ? pad_in : (p == 1) ? core_dout : core_oe;
  endfunction
  function automatic logic pce(int p);
    return (p == 0) ? ce_in : ce_out;
  endfunction
  function automatic logic pout(int p);
    return (p == 0) ? core_din : (p == 1) ? pad_dout : pad_oe;
  endfunction
  // one sampling step of the reference element
  function automatic logic step(logic [6:0] c, logic q, logic d, logic ce, logic s);
    if (s ^ c[3])       return c[5];
    else if (ce ^ c[2]) return d;
    else                return q;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tg);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", tg, act, exp);
    end
  endtask

  // driver: one clock cycle, inputs applied 2 ns after the rising edge
  task automatic cyc(input logic nrst, input logic [20:0] ncfg,
                     input logic [2:0] nd, input logic [2:0] nctl);
    logic [6:0] c;
    item_t      it;
    string      tg;
    @(posedge clk);
    for (int p = 0; p < 3; p++) begin
      c = pcfg(p);
      if (!rst_n || rst_cnt > 0)  mq[p] = c[5];
      else if (!c[0] && !c[1])    mq[p] = step(c, mq[p], pd(p), pce(p), sr);
    end
    if (rst_cnt > 0) rst_cnt--;
    for (int p = 0; p < 3; p++) begin
      c = pcfg(p);
      if (rst_n && rst_cnt == 0 && c[0] && !c[1])
        mq[p] = step(c, mq[p], pd(p), pce(p), sr);
    end
    #2;
    if (!rst_n && nrst) rst_cnt = 2;
    rst_n = nrst;
    {cfg_oe, cfg_out, cfg_in} = ncfg;
    {core_oe, core_dout, pad_in} = nd;
    {sr, ce_out, ce_in} = nctl;
    for (int p = 0; p < 3; p++) begin
      c = pcfg(p);
      if (!rst_n || rst_cnt > 0) begin
        mq[p] = c[5];
        tg = "R7";
      end else begin
        if (!c[0] && !c[1]) begin
          if (c[4] && (sr ^ c[3])) mq[p] = c[5];
        end else begin
          mq[p] = step(c, mq[p], pd(p), pce(p), sr);
        end
        if (c[4] && (sr ^ c[3]))  tg = "R5 R6";
        else if (sr ^ c[3])       tg = "R4 R6";
        else if (c[0])            tg = "R2 R3";
        else                      tg = "R1 R3";
      end
      if (c[6]) tg = "R8";
      it.path = p;
      it.exp  = c[6] ? pd(p) : mq[p];
      it.tag  = tg;
      sb_q.push_back(it);
    end
  endtask

  // monitor: samples 6 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #6;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk(pout(it.path), it.exp, $sformatf("%s R9 path%0d", it.tag, it.path));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; rst_cnt = 0; mq = '0;
    rst_n = 1'b0; cfg_in = '0; cfg_out = '0; cfg_oe = '0;
    ce_in = 1'b0; ce_out = 1'b0; sr = 1'b0;
    pad_in = 1'b0; core_dout = 1'b0; core_oe = 1'b0;

    // reset state, R7
    cyc(1'b0, 21'd0, 3'b111, 3'b011);
    cyc(1'b0, 21'd0, 3'b111, 3'b011);

    // every configuration on every path, random traffic
    for (int c = 0; c < 64; c++) begin
      logic [20:0] nc;
      for (int p = 0; p < 3; p++)
        nc[p*7 +: 7] = {((c + p) % 9 == 0), 6'((c + 21*p) % 64)};
      cyc(1'b0, nc, 3'($urandom), 3'($urandom));
      cyc(1'b0, nc, 3'($urandom), 3'($urandom));
      for (int k = 0; k < 22; k++)
        cyc(1'b1, nc, 3'($urandom),
            {(($urandom % 4) == 0) ^ nc[3], 2'($urandom)});
    end

    // R7: enable held through reset release, first capture on third rising edge
    cyc(1'b0, 21'd0, 3'b010, 3'b010);
    cyc(1'b0, 21'd0, 3'b010, 3'b010);
    for (int k = 0; k < 5; k++) cyc(1'b1, 21'd0, 3'b010, 3'b010);

    // R2: low-level gate latch, data change inside and outside the open gate
    cyc(1'b0, 21'b0000000_0000000_0000011, 3'b000, 3'b001);
    cyc(1'b0, 21'b0000000_0000000_0000011, 3'b000, 3'b001);
    for (int k = 0; k < 4; k++) cyc(1'b1, 21'b0000000_0000000_0000011, 3'b000, 3'b001);
    @(posedge clk);
    #5;
    pad_in = 1'b1;
    #1;
    chk(core_din, 1'b1, "R2 open gate follows");
    @(posedge clk);
    #1;
    pad_in = 1'b0;
    #1;
    chk(core_din, 1'b1, "R2 closed gate holds");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule